// File: doc/BRIEF.md
# Split-Butterfly Eight-Point Walsh-Hadamard Transform

This block computes an eight-point Walsh-Hadamard transform in natural (Sylvester) order. Every clock it takes eight signed samples in parallel and puts out eight signed coefficients. It reaches one full transform per clock, and each result appears three clocks after its input. It contains no multiplier. The transform is split into a radix-2 input butterfly followed by two identical four-point cores.

The butterfly pairs each sample with the sample four positions higher. Their sums form a low half-sequence and their differences form a high half-sequence. Both half-sequences are registered. Each then enters its own two-stage pipelined four-point core. The low core produces coefficients 0 to 3 and the high core produces coefficients 4 to 7. A valid flag travels alongside the data so that downstream logic knows which coefficients belong to real input.

The sample width is a parameter. Each adder stage adds one bit of width, so the output is three bits wider than the input. No sum can wrap. Output scaling, sequency reordering and serial-to-parallel conversion are left to neighbouring blocks.

Top module: `wht8_split`

## Requirements
- R1: For k in 0..3, coefficient k equals the natural-order four-point transform of the low sequence a(i) = x(i) + x(i+4), i = 0..3.
- R2: For k in 4..7, coefficient k equals the natural-order four-point transform of the high sequence b(i) = x(i) - x(i+4), i = 0..3.
- R3: Every coefficient satisfies X(k) = sum over n = 0..7 of s(k,n)·x(n), where s(k,n) is -1 when the bitwise AND of k and n has an odd number of ones and +1 otherwise. Sample n sits at `in_samples[n*IN_W +: IN_W]` and coefficient k sits at `out_coefs[k*OUT_W +: OUT_W]`, both in two's complement.
- R4: The coefficients for the samples captured at a rising edge appear after the third rising edge that follows. A new transform is accepted on every clock.
- R5: `out_valid` equals `in_valid` delayed by exactly three clocks.
- R6: OUT_W = IN_W + 3, and no input, including full-scale negative and positive patterns, causes any coefficient to wrap.
- R7: While `rst_n` is low, `out_valid` is 0 and all coefficients are 0. Reset takes effect immediately, without waiting for a clock edge.
- R8: The data path advances on every clock regardless of `in_valid`. Samples presented with `in_valid` low still produce their coefficients three clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the current input samples as meaningful |
| in_samples | input | 8*IN_W | Eight signed samples, sample n at bits n*IN_W upward |
| out_valid | output | 1 | in_valid delayed three clocks |
| out_coefs | output | 8*OUT_W | Eight signed coefficients, coefficient k at bits k*OUT_W upward |

## Verification
The bench builds the block at the default width IN_W = 8, which makes OUT_W = 11. At this width the extreme sample values -128 and +127 can be driven directly. Driving them in the sign pattern of each transform row pushes every coefficient to its widest reachable value (-1024, 1016 and 1020), which exercises the width-growth argument behind R6. The expected coefficients are computed from the full eight-by-eight sign rule rather than from the butterfly split, so an error in pairing, in sign or in core ordering shows up as a coefficient mismatch. The bench also drops in_valid for some cycles and applies reset in the middle of traffic.

// File: rtl/wht8_pkg.sv
package wht8_pkg;
   // transform size and its split
   localparam int NPTS  = 8;
   localparam int HALF  = NPTS / 2;
   // register stages from input to output: butterfly + two core stages
   localparam int LAT   = 3;
   // width added by log2(NPTS) adder levels
   localparam int GROW  = $clog2(NPTS);

   // 1 when the Sylvester matrix entry (k,n) is -1
   function automatic logic neg_entry(input int k, input int n);
      return ($countones(k & n) % 2) == 1;
   endfunction
endpackage

// File: rtl/wht_bfly.sv
// Radix-2 input butterfly: pairs element i with element i+HALF, registered.
module wht_bfly #(
   parameter int W    = 8,
   parameter int HALF = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [2*HALF*W-1:0]     din,
   output logic [HALF*(W+1)-1:0]   sum_o,
   output logic [HALF*(W+1)-1:0]   dif_o
);
   localparam int OW = W + 1;

   for (genvar i = 0; i < HALF; i++) begin : g_pair
      logic signed [OW-1:0] lo_e, hi_e;
      assign lo_e = OW'($signed(din[i*W +: W]));
      assign hi_e = OW'($signed(din[(i+HALF)*W +: W]));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sum_o[i*OW +: OW] <= '0;
            dif_o[i*OW +: OW] <= '0;
         end else begin
            sum_o[i*OW +: OW] <= lo_e + hi_e;
            dif_o[i*OW +: OW] <= lo_e - hi_e;
         end
      end
   end
endmodule

// File: rtl/wht4_core.sv
// Two-stage pipelined natural-order four-point Hadamard core.
module wht4_core #(
   parameter int W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [4*W-1:0]     din,
   output logic [4*(W+2)-1:0] dout
);
   localparam int W1 = W + 1;
   localparam int W2 = W + 2;

   logic signed [W1-1:0] e0, e1, e2, e3;
   logic signed [W1-1:0] p0, p1, p2, p3;
   logic signed [W2-1:0] q0, q1, q2, q3;

   assign e0 = W1'($signed(din[0*W +: W]));
   assign e1 = W1'($signed(din[1*W +: W]));
   assign e2 = W1'($signed(din[2*W +: W]));
   assign e3 = W1'($signed(din[3*W +: W]));

   // stage one: adjacent pair butterflies
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p0 <= '0; p1 <= '0; p2 <= '0; p3 <= '0;
      end else begin
         p0 <= e0 + e1;
         p1 <= e0 - e1;
         p2 <= e2 + e3;
         p3 <= e2 - e3;
      end
   end

   assign q0 = W2'(p0);
   assign q1 = W2'(p1);
   assign q2 = W2'(p2);
   assign q3 = W2'(p3);

   // stage two: pairs two apart, outputs land in natural order
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
      end else begin
         dout[0*W2 +: W2] <= q0 + q2;
         dout[1*W2 +: W2] <= q1 + q3;
         dout[2*W2 +: W2] <= q0 - q2;
         dout[3*W2 +: W2] <= q1 - q3;
      end
   end
endmodule

// File: rtl/wht8_split.sv
module wht8_split
   import wht8_pkg::*;
#(
   parameter int IN_W = 8,
   localparam int OUT_W = IN_W + GROW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [NPTS*IN_W-1:0]  in_samples,
   output logic                  out_valid,
   output logic [NPTS*OUT_W-1:0] out_coefs
);
   localparam int BF_W = IN_W + 1;

   if (IN_W < 2) begin : g_bad_width
      $error("wht8_split: IN_W must be at least 2");
   end
   if (OUT_W != BF_W + 2) begin : g_bad_growth
      $error("wht8_split: width growth does not match pipeline");
   end

   logic [HALF*BF_W-1:0] low_seq, high_seq;

   wht_bfly #(.W(IN_W), .HALF(HALF)) u_bfly (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (in_samples),
      .sum_o (low_seq),
      .dif_o (high_seq)
   );

   // half 0 (sums) feeds coefficients 0..3, half 1 (differences) 4..7
   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF*BF_W-1:0] seq;
      if (h == 0) begin : g_lo
         assign seq = low_seq;
      end else begin : g_hi
         assign seq = high_seq;
      end
      wht4_core #(.W(BF_W)) u_core (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (seq),
         .dout  (out_coefs[h*HALF*OUT_W +: HALF*OUT_W])
      );
   end

   logic [LAT-1:0] vpipe;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= {vpipe[LAT-2:0], in_valid};
   end
   assign out_valid = vpipe[LAT-1];
endmodule

// File: rtl/wht8_split_chk.sv
module wht8_split_chk
   import wht8_pkg::*;
#(
   parameter int IN_W  = 8,
   parameter int OUT_W = 11
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic [NPTS*IN_W-1:0]  in_samples,
   input logic                  out_valid,
   input logic [NPTS*OUT_W-1:0] out_coefs
);
   // edges seen since reset release, saturating at LAT
   logic [2:0] seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   seen <= '0;
      else if (int'(seen) < LAT)    seen <= seen + 3'd1;
   end

   logic signed [OUT_W-1:0] ref0, ref4, ref7;
   always_comb begin
      ref0 = '0; ref4 = '0; ref7 = '0;
      for (int n = 0; n < NPTS; n++) begin
         ref0 = ref0 + OUT_W'($signed(in_samples[n*IN_W +: IN_W]));
         if (neg_entry(4, n)) ref4 = ref4 - OUT_W'($signed(in_samples[n*IN_W +: IN_W]));
         else                 ref4 = ref4 + OUT_W'($signed(in_samples[n*IN_W +: IN_W]));
         if (neg_entry(7, n)) ref7 = ref7 - OUT_W'($signed(in_samples[n*IN_W +: IN_W]));
         else                 ref7 = ref7 + OUT_W'($signed(in_samples[n*IN_W +: IN_W]));
      end
   end

   assert_valid_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(seen) >= LAT) |-> (out_valid == $past(in_valid, 3)));

   assert_low_dc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(seen) >= LAT) |-> ($signed(out_coefs[0 +: OUT_W]) == $past(ref0, 3)));

   assert_high_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(seen) >= LAT) |-> ($signed(out_coefs[4*OUT_W +: OUT_W]) == $past(ref4, 3)));

   assert_last_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(seen) >= LAT) |-> ($signed(out_coefs[7*OUT_W +: OUT_W]) == $past(ref7, 3)));

   assert_reset_clear_R7: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && (out_coefs == '0)));
endmodule

bind wht8_split wht8_split_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_samples (in_samples),
   .out_valid  (out_valid),
   .out_coefs  (out_coefs)
);

// File: tb/wht8_split_bench.sv
module wht8_split_bench;
   localparam int CLK_PERIOD = 10;
   localparam int IN_W  = 8;
   localparam int OUT_W = IN_W + 3;
   localparam int NP    = 8;
   localparam int LAT   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [NP*IN_W-1:0]  in_samples = '0;
   logic                out_valid;
   logic [NP*OUT_W-1:0] out_coefs;

   wht8_split #(.IN_W(IN_W)) u_wht8_split (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
      .out_valid(out_valid), .out_coefs(out_coefs)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct packed {
      logic                v;
      logic [NP*OUT_W-1:0] c;
      int                  due;
   } item_t;

   item_t sb[$];
   int edge_n   = 0;
   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always @(posedge clk) edge_n <= edge_n + 1;

   // expected coefficients from the full 8x8 sign rule
   function automatic logic [NP*OUT_W-1:0] expect_of(input logic [NP*IN_W-1:0] s);
      logic [NP*OUT_W-1:0] r;
      r = '0;
      for (int k = 0; k < NP; k++) begin
         int acc;
         acc = 0;
         for (int n = 0; n < NP; n++) begin
            int v;
            v = int'($signed(s[n*IN_W +: IN_W]));
            if (($countones(k & n) % 2) == 1) acc -= v;
            else                              acc += v;
         end
         r[k*OUT_W +: OUT_W] = OUT_W'(acc);
      end
      return r;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [NP*IN_W-1:0] s);
      @(negedge clk);
      in_valid   = v;
      in_samples = s;
      sb.push_back('{v: v, c: expect_of(s), due: edge_n + LAT});
   endtask

   function automatic logic [NP*IN_W-1:0] fill(input int pos_val, input int neg_val, input int row);
      logic [NP*IN_W-1:0] s;
      for (int n = 0; n < NP; n++)
         s[n*IN_W +: IN_W] = (($countones(row & n) % 2) == 1) ? IN_W'(neg_val) : IN_W'(pos_val);
      return s;
   endfunction

   // scoreboard monitor
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (rst_n) begin
            while (sb.size() > 0 && sb[0].due <= edge_n) begin
               item_t it;
               it = sb.pop_front();
               if (it.due == edge_n) begin
                  check("R5 R4 valid", int'(out_valid), int'(it.v));
                  for (int k = 0; k < NP; k++) begin
                     if (k < 4)
                        check($sformatf("R1 R3 R8 coef%0d", k),
                              int'($signed(out_coefs[k*OUT_W +: OUT_W])),
                              int'($signed(it.c[k*OUT_W +: OUT_W])));
                     else
                        check($sformatf("R2 R3 R8 coef%0d", k),
                              int'($signed(out_coefs[k*OUT_W +: OUT_W])),
                              int'($signed(it.c[k*OUT_W +: OUT_W])));
                  end
               end else begin
                  check("R4 late result", it.due, edge_n);
               end
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R4 act=%0d exp=%0d", edge_n, 0);
      finish_run();
   end

   initial begin
      // R7: reset state
      repeat (3) @(negedge clk);
      check("R7 valid in reset", int'(out_valid), 0);
      check("R7 coefs in reset", int'(out_coefs != '0), 0);
      @(negedge clk);
      rst_n = 1'b1;

      drive(1'b1, '0);
      // impulses at each position: row signs become visible
      for (int n = 0; n < NP; n++) begin
         logic [NP*IN_W-1:0] s;
         s = '0;
         s[n*IN_W +: IN_W] = IN_W'(1);
         drive(1'b1, s);
      end
      // R6: full-scale patterns
      drive(1'b1, fill(127, 127, 0));
      drive(1'b1, fill(-128, -128, 0));
      for (int r = 1; r < NP; r++) begin
         drive(1'b1, fill(127, -128, r));
         drive(1'b1, fill(-128, 127, r));
      end
      // R8, R5: random data with valid gaps
      for (int t = 0; t < 60; t++) begin
         logic [NP*IN_W-1:0] s;
         for (int n = 0; n < NP; n++) s[n*IN_W +: IN_W] = IN_W'($urandom);
         drive(1'(($urandom % 3) != 0), s);
      end
      repeat (LAT + 2) @(negedge clk);
      check("R4 queue drained", sb.size(), 0);

      // R7: reset in the middle of traffic clears immediately
      drive(1'b1, fill(100, -50, 3));
      drive(1'b1, fill(-7, 77, 5));
      @(negedge clk);
      rst_n = 1'b0;
      sb.delete();
      #1;
      check("R7 valid after async reset", int'(out_valid), 0);
      check("R7 coefs after async reset", int'(out_coefs != '0), 0);
      @(negedge clk);
      rst_n = 1'b1;
      in_valid = 1'b0;
      for (int t = 0; t < 10; t++) begin
         logic [NP*IN_W-1:0] s;
         for (int n = 0; n < NP; n++) s[n*IN_W +: IN_W] = IN_W'($urandom);
         drive(1'b1, s);
      end
      repeat (LAT + 2) @(negedge clk);
      check("R4 queue drained after reset", sb.size(), 0);
      finish_run();
   end
endmodule